// File: doc/BRIEF.md
# Dual-Address Diagnostic Register Target

This block is a two-wire serial target, oversampled on the system clock, that answers on two 7-bit bus addresses. Address 0x50 selects a 256-byte identification map. That map is read-only, and its contents are computed from parameters. Address 0x51 selects a 256-byte diagnostic map. The diagnostic map holds threshold bytes, five live 16-bit monitor words, a status/control byte and a writable user area. A single byte pointer is shared by both maps. The first data byte of a write transaction loads the pointer. Each byte that is then read or stored advances it.

The host sets the pointer with a short write, issues a repeated start and streams bytes back. When a read begins on the high byte of a monitor word, all five words are frozen into a shadow copy for the rest of that transaction, so high and low bytes always form a matching pair. The control byte carries a soft transmit-disable bit. That bit is combined with a hardware pin to drive the `tx_disable` output.

Top module: `diag_reg_target`

## Requirements
- R1: Address bytes 0xA0/0xA1 (0x50) and 0xA2/0xA3 (0x51) are acknowledged, with bit 0 of the address byte selecting read (1) or write (0). Any other address is not acknowledged and changes no state.
- R2: The first data byte of a write loads the shared pointer. The pointer advances by one after every byte read or stored and wraps from 255 to 0. A read issued without a pointer write continues from the current pointer.
- R3: Identification byte a reads (a*ROM_MUL + ID_BASE) mod 256 (defaults 3 and 0x11). Data writes to that map are acknowledged but change no content.
- R4: Diagnostic bytes 0 to 95 read (a*ROM_MUL + DIAG_BASE) mod 256 (DIAG_BASE default 0x40). They are read-only.
- R5: Diagnostic bytes 128 to 247 are read/write storage. Bytes 106–109, 111–127 and 248–255 read 0 and discard writes.
- R6: Diagnostic byte 110 reads {pin, soft, 0, 1, spare, 0, sig_det, ~mon_ready} from bit 7 down to bit 0. Only bit 6 (soft) and bit 3 (spare) store written values.
- R7: `tx_disable` is high two clocks after `tx_dis_pin` is high, and whenever the soft bit is set. It is low only when both are clear.
- R8: Bytes 96 to 105 hold the monitor words high byte first, in this order: temperature, supply, bias, transmit power, receive power.
- R9: A read transaction whose first byte is at an even address from 96 to 104 returns monitor bytes from a copy taken at the address acknowledge. A read that starts at an odd monitor address returns live values.
- R10: A write accepts at most 8 data bytes after the pointer byte. Later bytes are not acknowledged, are discarded and do not move the pointer.
- R11: A stop condition releases SDA on the next clock. A start condition at any point restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | Pull SDA low when 1 (open drain) |
| tx_dis_pin | input | 1 | Hardware transmit-disable request |
| sig_det | input | 1 | Receiver signal-detect level |
| mon_ready | input | 1 | Monitor data valid (high = ready) |
| mon_temp | input | 16 | Temperature word |
| mon_vcc | input | 16 | Supply word |
| mon_bias | input | 16 | Transmit bias word |
| mon_txpwr | input | 16 | Transmit power word |
| mon_rxpwr | input | 16 | Receive power word |
| tx_disable | output | 1 | Combined transmit-disable output |

## Verification
Some properties are checked by assertions on every cycle:
- SDA is released after a stop.
- At most one pointer event occurs per cycle.
- The pointer wraps from 255 to 0.
- The shadow copy holds steady once taken.
- `tx_disable` follows the pin and the soft bit.
- The write-count limit is respected.

Other behaviours are shown only by the bench's bus scenarios:
- Map contents and per-bit control-byte rules.
- Pointer continuation across transactions.
- Acknowledge versus no-acknowledge on the ninth data byte.
- The matching high/low monitor pair when the inputs change during a read, compared with the live result from an odd start.

// File: rtl/diag_pkg.sv
package diag_pkg;
  localparam logic [6:0] ID_DEV_ADDR   = 7'h50;
  localparam logic [6:0] DIAG_DEV_ADDR = 7'h51;
  localparam int MON_WORDS = 5;
  localparam int MON_W     = 16;
  localparam int MON_BITS  = MON_WORDS * MON_W;
  localparam int MON_BYTES = MON_BITS / 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WBYTE, ST_WACK, ST_RBYTE, ST_RACK
  } tw_state_e;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_d, sda_d, scl_now, sda_now;

  assign scl_now = scl_sr[STAGES-1];
  assign sda_now = sda_sr[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_d  <= scl_now;
      sda_d  <= sda_now;
    end
  end

  assign sda_lvl   = sda_now;
  assign scl_rise  = scl_now & ~scl_d;
  assign scl_fall  = ~scl_now & scl_d;
  assign bus_start = scl_now & scl_d & sda_d & ~sda_now;
  assign bus_stop  = scl_now & scl_d & ~sda_d & sda_now;
endmodule

// File: rtl/tw_target_fsm.sv
module tw_target_fsm
  import diag_pkg::*;
#(
  parameter int MAX_WR = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sda_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       ptr_wr,
  output logic       data_wr,
  output logic [7:0] wr_byte,
  output logic       rd_adv,
  output logic       snap_req,
  output logic       map_diag,
  output logic       xfer_end
);
  localparam int CW = $clog2(MAX_WR + 1);

  tw_state_e     state;
  logic [3:0]    bit_cnt;
  logic [7:0]    shreg;
  logic          is_read, first_b, m_ack;
  logic [CW-1:0] wr_cnt;
  logic          addr_hit;

  assign addr_hit = (shreg[7:1] == ID_DEV_ADDR) || (shreg[7:1] == DIAG_DEV_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      sda_oe   <= 1'b0;
      is_read  <= 1'b0;
      first_b  <= 1'b0;
      m_ack    <= 1'b0;
      wr_cnt   <= '0;
      map_diag <= 1'b0;
      ptr_wr   <= 1'b0;
      data_wr  <= 1'b0;
      wr_byte  <= '0;
      rd_adv   <= 1'b0;
      snap_req <= 1'b0;
      xfer_end <= 1'b0;
    end else begin
      ptr_wr   <= 1'b0;
      data_wr  <= 1'b0;
      rd_adv   <= 1'b0;
      snap_req <= 1'b0;
      xfer_end <= bus_start | bus_stop;
      if (bus_start) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (bus_stop) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR, ST_WBYTE: begin
            if (scl_rise && bit_cnt < 4'd8) begin
              shreg   <= {shreg[6:0], sda_lvl};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              if (state == ST_ADDR) begin
                if (addr_hit) begin
                  sda_oe   <= 1'b1;
                  state    <= ST_AACK;
                  is_read  <= shreg[0];
                  map_diag <= (shreg[7:1] == DIAG_DEV_ADDR);
                  snap_req <= shreg[0] & (shreg[7:1] == DIAG_DEV_ADDR);
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                state   <= ST_WACK;
                wr_byte <= shreg;
                if (first_b) begin
                  first_b <= 1'b0;
                  ptr_wr  <= 1'b1;
                  sda_oe  <= 1'b1;
                end else if (wr_cnt < CW'(MAX_WR)) begin
                  wr_cnt  <= wr_cnt + 1'b1;
                  data_wr <= 1'b1;
                  sda_oe  <= 1'b1;
                end else begin
                  sda_oe <= 1'b0;
                end
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (is_read) begin
                shreg  <= rd_data;
                sda_oe <= ~rd_data[7];
                state  <= ST_RBYTE;
              end else begin
                sda_oe  <= 1'b0;
                first_b <= 1'b1;
                wr_cnt  <= '0;
                state   <= ST_WBYTE;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              state   <= ST_WBYTE;
            end
          end
          ST_RBYTE: begin
            if (scl_fall) begin
              if (bit_cnt == 4'd7) begin
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
                rd_adv  <= 1'b1;
                state   <= ST_RACK;
              end else begin
                bit_cnt <= bit_cnt + 4'd1;
                shreg   <= {shreg[6:0], 1'b0};
                sda_oe  <= ~shreg[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) m_ack <= ~sda_lvl;
            else if (scl_fall) begin
              if (m_ack) begin
                shreg  <= rd_data;
                sda_oe <= ~rd_data[7];
                state  <= ST_RBYTE;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R11: a stop condition leaves the data line released
  a_r11_stop_release: assert property (@(posedge clk) disable iff (rst)
    bus_stop |=> !sda_oe);

  // R2: pointer load, store and read advance never coincide
  a_r2_one_ptr_event: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ptr_wr, data_wr, rd_adv}));

  // R1: an unknown address is never acknowledged
  a_r1_nack_foreign: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADDR && scl_fall && bit_cnt == 4'd8 && !addr_hit && !bus_start && !bus_stop)
      |=> !sda_oe);

  // R10: stored data bytes per transaction stay within the limit
  a_r10_write_limit: assert property (@(posedge clk) disable iff (rst)
    data_wr |-> (wr_cnt <= CW'(MAX_WR)));
endmodule

// File: rtl/diag_regfile.sv
module diag_regfile
  import diag_pkg::*;
#(
  parameter int         ROM_MUL   = 3,
  parameter logic [7:0] ID_BASE   = 8'h11,
  parameter logic [7:0] DIAG_BASE = 8'h40,
  parameter int         MON_LO    = 96,
  parameter int         CTRL_AT   = 110,
  parameter int         USER_LO   = 128,
  parameter int         USER_HI   = 247
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ptr_wr,
  input  logic                data_wr,
  input  logic [7:0]          wr_byte,
  input  logic                rd_adv,
  input  logic                snap_req,
  input  logic                map_diag,
  input  logic                xfer_end,
  input  logic                tx_dis_pin,
  input  logic                sig_det,
  input  logic                mon_ready,
  input  logic [MON_BITS-1:0] mon_flat,
  output logic [7:0]          rd_data,
  output logic                tx_disable
);
  localparam int         USER_DEPTH = USER_HI - USER_LO + 1;
  localparam int         UA_W       = $clog2(USER_DEPTH);
  localparam logic [7:0] MON_LO_B   = 8'(MON_LO);
  localparam logic [7:0] MON_END_B  = 8'(MON_LO + MON_BYTES);
  localparam logic [7:0] CTRL_B     = 8'(CTRL_AT);
  localparam logic [7:0] USER_LO_B  = 8'(USER_LO);
  localparam logic [7:0] USER_HI_B  = 8'(USER_HI);

  logic [7:0]          ptr;
  logic                soft_dis, spare;
  logic                pin_q, sd_q, rdy_q;
  logic [MON_BITS-1:0] live_q, shadow;
  logic                shadow_valid;
  logic [7:0]          mem [USER_DEPTH];
  logic [7:0]          ram_q, rd_nxt, mon_byte, ctrl_rd, mon_idx;
  logic [UA_W-1:0]     ram_a;
  logic                in_user, in_mon, snap_ok;
  logic [MON_BITS-1:0] mon_src;

  function automatic logic [7:0] rom_byte(input logic [7:0] a, input logic [7:0] base);
    logic [15:0] t;
    t = 16'(a) * 16'(ROM_MUL) + 16'(base);
    return t[7:0];
  endfunction

  assign in_user = (ptr >= USER_LO_B) && (ptr <= USER_HI_B);
  assign in_mon  = (ptr >= MON_LO_B) && (ptr < MON_END_B);
  assign snap_ok = in_mon && !ptr[0];
  assign ram_a   = UA_W'(ptr - USER_LO_B);
  assign mon_idx = ptr - MON_LO_B;
  assign mon_src = shadow_valid ? shadow : live_q;
  assign mon_byte = 8'(mon_src >> (8 * (MON_BYTES - 1 - int'(mon_idx))));
  assign ctrl_rd = {pin_q, soft_dis, 1'b0, 1'b1, spare, 1'b0, sd_q, ~rdy_q};

  // input capture, no reset needed
  always_ff @(posedge clk) begin
    pin_q  <= tx_dis_pin;
    sd_q   <= sig_det;
    rdy_q  <= mon_ready;
    live_q <= mon_flat;
  end

  // user storage, block-RAM friendly
  always_ff @(posedge clk) begin
    if (data_wr && map_diag && in_user) mem[ram_a] <= wr_byte;
    if (in_user) ram_q <= mem[ram_a];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr          <= '0;
      soft_dis     <= 1'b0;
      spare        <= 1'b0;
      shadow       <= '0;
      shadow_valid <= 1'b0;
      tx_disable   <= 1'b0;
    end else begin
      tx_disable <= pin_q | soft_dis;
      if (ptr_wr) ptr <= wr_byte;
      else if (data_wr || rd_adv) ptr <= ptr + 8'd1;
      if (data_wr && map_diag && ptr == CTRL_B) begin
        soft_dis <= wr_byte[6];
        spare    <= wr_byte[3];
      end
      if (snap_req && snap_ok) begin
        shadow       <= live_q;
        shadow_valid <= 1'b1;
      end else if (xfer_end) begin
        shadow_valid <= 1'b0;
      end
    end
  end

  always_comb begin
    if (!map_diag)            rd_nxt = rom_byte(ptr, ID_BASE);
    else if (ptr < MON_LO_B)  rd_nxt = rom_byte(ptr, DIAG_BASE);
    else if (in_mon)          rd_nxt = mon_byte;
    else if (ptr == CTRL_B)   rd_nxt = ctrl_rd;
    else if (in_user)         rd_nxt = ram_q;
    else                      rd_nxt = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_nxt;
  end

  // R7: the hardware pin forces the output two clocks later
  a_r7_pin_forces: assert property (@(posedge clk) disable iff (rst)
    ($past(tx_dis_pin, 2) && !$past(rst)) |-> tx_disable);

  // R7: the soft bit forces the output on the next clock
  a_r7_soft_forces: assert property (@(posedge clk) disable iff (rst)
    soft_dis |=> tx_disable);

  // R9: a taken copy stays frozen until a new capture
  a_r9_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    (shadow_valid && !snap_req) |=> $stable(shadow));

  // R2: pointer wraps from the top to zero
  a_r2_ptr_wrap: assert property (@(posedge clk) disable iff (rst)
    (rd_adv && ptr == 8'hFF) |=> (ptr == 8'h00));
endmodule

// File: rtl/diag_reg_target.sv
module diag_reg_target
  import diag_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         MAX_WR      = 8,
  parameter int         ROM_MUL     = 3,
  parameter logic [7:0] ID_BASE     = 8'h11,
  parameter logic [7:0] DIAG_BASE   = 8'h40
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic        tx_dis_pin,
  input  logic        sig_det,
  input  logic        mon_ready,
  input  logic [15:0] mon_temp,
  input  logic [15:0] mon_vcc,
  input  logic [15:0] mon_bias,
  input  logic [15:0] mon_txpwr,
  input  logic [15:0] mon_rxpwr,
  output logic        tx_disable
);
  logic sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
  logic ptr_wr, data_wr, rd_adv, snap_req, map_diag, xfer_end;
  logic [7:0] wr_byte, rd_data;
  logic [MON_BITS-1:0] mon_flat;

  assign mon_flat = {mon_temp, mon_vcc, mon_bias, mon_txpwr, mon_rxpwr};

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  tw_target_fsm #(.MAX_WR(MAX_WR)) u_fsm (
    .clk(clk), .rst(rst), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop),
    .rd_data(rd_data), .sda_oe(sda_oe), .ptr_wr(ptr_wr), .data_wr(data_wr),
    .wr_byte(wr_byte), .rd_adv(rd_adv), .snap_req(snap_req),
    .map_diag(map_diag), .xfer_end(xfer_end)
  );

  diag_regfile #(
    .ROM_MUL(ROM_MUL), .ID_BASE(ID_BASE), .DIAG_BASE(DIAG_BASE)
  ) u_regs (
    .clk(clk), .rst(rst), .ptr_wr(ptr_wr), .data_wr(data_wr),
    .wr_byte(wr_byte), .rd_adv(rd_adv), .snap_req(snap_req),
    .map_diag(map_diag), .xfer_end(xfer_end), .tx_dis_pin(tx_dis_pin),
    .sig_det(sig_det), .mon_ready(mon_ready), .mon_flat(mon_flat),
    .rd_data(rd_data), .tx_disable(tx_disable)
  );
endmodule

// File: tb/sim_diag_reg_target.sv
module sim_diag_reg_target;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_bus, tx_disable;
  logic tx_dis_pin = 1'b0, sig_det = 1'b0, mon_ready = 1'b0;
  logic [15:0] mon_temp = 16'h0, mon_vcc = 16'h0, mon_bias = 16'h0;
  logic [15:0] mon_txpwr = 16'h0, mon_rxpwr = 16'h0;

  assign sda_bus = sda_m & ~sda_oe;

  diag_reg_target u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .tx_dis_pin(tx_dis_pin), .sig_det(sig_det), .mon_ready(mon_ready),
    .mon_temp(mon_temp), .mon_vcc(mon_vcc), .mon_bias(mon_bias),
    .mon_txpwr(mon_txpwr), .mon_rxpwr(mon_rxpwr), .tx_disable(tx_disable)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  // scoreboard
  logic [7:0] exp_v[$];
  string      exp_r[$];
  logic [7:0] act_q[$];
  logic [7:0] m_a, m_e;
  string      m_r;
  logic [7:0] wbuf [16];

  always @(negedge clk) begin
    if (act_q.size() > 0 && exp_v.size() > 0) begin
      m_a = act_q.pop_front();
      m_e = exp_v.pop_front();
      m_r = exp_r.pop_front();
      checks++;
      if (m_a !== m_e) begin
        errors++;
        $display("FAIL %s: read %02h expected %02h", m_r, m_a, m_e);
      end
    end
  end

  function automatic logic [7:0] id_rom(input int a);
    return 8'((a * 3 + 'h11) & 'hFF);
  endfunction
  function automatic logic [7:0] dg_rom(input int a);
    return 8'((a * 3 + 'h40) & 'hFF);
  endfunction

  task automatic expect_b(input logic [7:0] v, input string r);
    exp_v.push_back(v);
    exp_r.push_back(r);
  endtask

  task automatic chk(input string r, input logic [7:0] a, input logic [7:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", r, a, e);
    end
  endtask

  task automatic hp(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hp(H);
    scl_m = 1'b1; hp(H);
    sda_m = 1'b0; hp(H);
    scl_m = 1'b0; hp(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hp(H);
    scl_m = 1'b1; hp(H);
    sda_m = 1'b1; hp(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hp(H);
      scl_m = 1'b1; hp(H);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; hp(H);
    scl_m = 1'b1; hp(H / 2);
    ack = ~sda_bus;
    hp(H / 2);
    scl_m = 1'b0;
  endtask

  task automatic read_byte(input bit last);
    logic [7:0] v;
    v = '0;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hp(H);
      scl_m = 1'b1; hp(H / 2);
      v = {v[6:0], sda_bus};
      hp(H / 2);
      scl_m = 1'b0;
    end
    sda_m = last; hp(H);
    scl_m = 1'b1; hp(H);
    scl_m = 1'b0;
    act_q.push_back(v);
  endtask

  task automatic addr_phase(input logic [6:0] dev, input bit rd, input bit exp_ack, input string r);
    bit a;
    send_byte({dev, rd}, a);
    chk(r, 8'(a), 8'(exp_ack));
  endtask

  // write: pointer byte then n data bytes from wbuf; bytes beyond 8 expect no ack
  task automatic wr_tx(input logic [6:0] dev, input logic [7:0] p, input int n, input string r);
    bit a;
    bus_start();
    addr_phase(dev, 1'b0, 1'b1, "R1 address ack");
    send_byte(p, a);
    chk("R2 pointer ack", 8'(a), 8'd1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a);
      chk(r, 8'(a), 8'(i < 8));
    end
    bus_stop();
  endtask

  task automatic rd_at(input logic [6:0] dev, input logic [7:0] p, input int n);
    bit a;
    bus_start();
    addr_phase(dev, 1'b0, 1'b1, "R1 address ack");
    send_byte(p, a);
    chk("R2 pointer ack", 8'(a), 8'd1);
    bus_start();
    addr_phase(dev, 1'b1, 1'b1, "R11 repeated start ack");
    for (int i = 0; i < n; i++) read_byte(i == n - 1);
    bus_stop();
  endtask

  task automatic rd_cur(input logic [6:0] dev, input int n);
    bus_start();
    addr_phase(dev, 1'b1, 1'b1, "R1 address ack");
    for (int i = 0; i < n; i++) read_byte(i == n - 1);
    bus_stop();
  endtask

  task automatic set_mon(input logic [15:0] base);
    mon_temp  = base;
    mon_vcc   = base + 16'h1111;
    mon_bias  = base + 16'h2222;
    mon_txpwr = base + 16'h3333;
    mon_rxpwr = base + 16'h4444;
  endtask

  task automatic expect_mon(input logic [15:0] base, input int from, input int to, input string r);
    logic [15:0] w;
    for (int a = from; a <= to; a++) begin
      w = base + 16'((a - 96) / 2) * 16'h1111;
      expect_b(((a - 96) % 2 == 0) ? w[15:8] : w[7:0], r);
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit a;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    hp(3);
    chk("R11 reset sda released", 8'(sda_oe), 8'd0);
    chk("R7 reset tx_disable low", 8'(tx_disable), 8'd0);

    // R3 identification map contents
    for (int i = 0; i < 4; i++) expect_b(id_rom(16 + i), "R3 id map read");
    rd_at(7'h50, 8'h10, 4);

    // R2 wrap and continuation
    expect_b(id_rom(254), "R2 wrap 254");
    expect_b(id_rom(255), "R2 wrap 255");
    expect_b(id_rom(0), "R2 wrap 0");
    expect_b(id_rom(1), "R2 wrap 1");
    rd_at(7'h50, 8'd254, 4);

    // R1 foreign address is refused and leaves the pointer alone
    bus_start();
    addr_phase(7'h52, 1'b0, 1'b0, "R1 foreign address nack");
    bus_stop();
    expect_b(id_rom(2), "R2 continue after reads");
    rd_cur(7'h50, 1);

    // R3 writes to identification map change nothing
    wbuf[0] = 8'hFF; wbuf[1] = 8'h00;
    wr_tx(7'h50, 8'd5, 2, "R3 id write ack");
    expect_b(id_rom(5), "R3 id unchanged 5");
    expect_b(id_rom(6), "R3 id unchanged 6");
    rd_at(7'h50, 8'd5, 2);

    // R4 thresholds read-only
    wbuf[0] = 8'h00;
    wr_tx(7'h51, 8'd2, 1, "R4 threshold write ack");
    for (int i = 0; i < 4; i++) expect_b(dg_rom(i), "R4 threshold read");
    rd_at(7'h51, 8'd0, 4);

    // R5 user area, edges and reserved bytes
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
    wr_tx(7'h51, 8'd128, 3, "R5 user write ack");
    wbuf[0] = 8'h7E;
    wr_tx(7'h51, 8'd247, 1, "R5 user write ack");
    wbuf[0] = 8'hFF;
    wr_tx(7'h51, 8'd107, 1, "R5 reserved write ack");
    wbuf[0] = 8'hFF;
    wr_tx(7'h51, 8'd250, 1, "R5 vendor write ack");
    expect_b(8'hA1, "R5 user 128"); expect_b(8'hB2, "R5 user 129");
    expect_b(8'hC3, "R5 user 130");
    rd_at(7'h51, 8'd128, 3);
    expect_b(8'h7E, "R5 user 247"); expect_b(8'h00, "R5 vendor 248 zero");
    rd_at(7'h51, 8'd247, 2);
    expect_b(8'h00, "R5 reserved 106"); expect_b(8'h00, "R5 reserved 107 after write");
    rd_at(7'h51, 8'd106, 2);
    expect_b(8'h00, "R5 vendor 250 after write");
    rd_at(7'h51, 8'd250, 1);

    // R6 control byte and R7 output
    tx_dis_pin = 1'b1; sig_det = 1'b1; mon_ready = 1'b1;
    hp(4);
    chk("R7 pin forces tx_disable", 8'(tx_disable), 8'd1);
    expect_b(8'h92, "R6 control pins reflected");
    rd_at(7'h51, 8'd110, 1);
    tx_dis_pin = 1'b0; sig_det = 1'b0; mon_ready = 1'b0;
    hp(4);
    chk("R7 tx_disable low with both clear", 8'(tx_disable), 8'd0);
    wbuf[0] = 8'hFF;
    wr_tx(7'h51, 8'd110, 1, "R6 control write ack");
    hp(4);
    chk("R7 soft bit forces tx_disable", 8'(tx_disable), 8'd1);
    expect_b(8'h59, "R6 control after 0xFF write");
    rd_at(7'h51, 8'd110, 1);
    wbuf[0] = 8'h00;
    wr_tx(7'h51, 8'd110, 1, "R6 control write ack");
    hp(4);
    chk("R7 tx_disable after soft clear", 8'(tx_disable), 8'd0);
    expect_b(8'h11, "R6 control after clear");
    rd_at(7'h51, 8'd110, 1);

    // R8/R9 coherent capture from an even start
    set_mon(16'h1234);
    hp(4);
    bus_start();
    addr_phase(7'h51, 1'b0, 1'b1, "R1 address ack");
    send_byte(8'd96, a);
    bus_start();
    addr_phase(7'h51, 1'b1, 1'b1, "R9 read ack");
    set_mon(16'hABCD);
    expect_mon(16'h1234, 96, 105, "R9 shadow monitor bytes (R8 order)");
    for (int i = 0; i < 10; i++) read_byte(i == 9);
    bus_stop();

    // R9 odd start reads live values
    bus_start();
    addr_phase(7'h51, 1'b0, 1'b1, "R1 address ack");
    send_byte(8'd97, a);
    bus_start();
    addr_phase(7'h51, 1'b1, 1'b1, "R9 read ack");
    set_mon(16'h5A00);
    hp(4);
    expect_mon(16'h5A00, 97, 98, "R9 odd start live (R8)");
    read_byte(1'b0); read_byte(1'b1);
    bus_stop();

    // R10 nine data bytes: last refused and discarded
    wbuf[0] = 8'h5A;
    wr_tx(7'h51, 8'd208, 1, "R10 setup write ack");
    for (int i = 0; i < 9; i++) wbuf[i] = 8'(8'h30 + i);
    wr_tx(7'h51, 8'd200, 9, "R10 write byte ack");
    for (int i = 0; i < 8; i++) expect_b(8'(8'h30 + i), "R10 stored byte");
    expect_b(8'h5A, "R10 ninth byte discarded");
    rd_at(7'h51, 8'd200, 9);

    hp(4);
    chk("R11 sda released after stop", 8'(sda_oe), 8'd0);

    hp(20);
    checks++;
    if (exp_v.size() != 0 || act_q.size() != 0) begin
      errors++;
      $display("FAIL R2 scoreboard: got %0d unmatched expected %0d", exp_v.size() + act_q.size(), 0);
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule